// File: doc/BRIEF.md
# Cache and Attraction-Memory Inclusion Coherence Handler

This block sits inside one processing node, between the processor cache and the local attraction memory of a cache-only memory machine. It takes network-side requests (invalidate, external read) and cache-side requests (shared eviction, exclusive eviction, write miss). Each request is resolved with a per-block inclusion bit, which records whether the cache also holds the block. The bit decides whether the handler must first go through the processor cache. Inclusion may be broken, so a block can live in the cache alone.

The attraction-memory tag and state array is a combinational lookup. The lookup answers presence, state, inclusion bit, stored data and whether a free slot exists for the request address. It is updated through a one-cycle write port. The cache receives commands (invalidate, fetch with downgrade to shared, fill, and an invalidate that the cache acknowledges directly to the home node), and returns acknowledgements with data. Network-side results are acknowledgements, read replies, writebacks and forwards to the home node. Each carries the block address and this node's ID. One request is handled at a time. While a cache acknowledgement is outstanding, new requests are held off.

Top module: `incl_coh_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1 and `cc_valid`, `net_valid` and `am_wr_en` are 0.
- R2: An invalidate (req_op 0) that finds the block present (hit and state not 0) with the inclusion bit set first issues a cache invalidate (cc_op 0) and waits. One cycle after the cache acknowledgement, it writes the block to state 0 (invalid) with the inclusion bit clear and sends an invalidate acknowledgement (net_op 0).
- R3: An invalidate that finds the block present with the inclusion bit clear writes the block invalid and sends net_op 0 in the next cycle, with no cache command.
- R4: An invalidate for a block not present issues cc_op 3 (the cache acknowledges the home node itself). It sends no network message and makes no memory write.
- R5: An external read (req_op 1) to a present block in state 2 (exclusive) with the inclusion bit set issues a fetch (cc_op 1) and waits. After the acknowledgement, it writes the returned data to memory in state 1 (shared) with the inclusion bit kept set, and replies to the requester (net_op 1) with that data.
- R6: An external read to any other present block replies at once with the stored data. An exclusive block is rewritten as shared with its inclusion bit unchanged. Shared (1) and master (3) blocks are not written.
- R7: An external read for a block not present fetches it from the cache (cc_op 1). After the acknowledgement it replies with the cache data and makes no memory write.
- R8: A shared eviction (req_op 2) of a present block only clears its inclusion bit and keeps its state, with no data write. With the block absent, it forwards a replacement message to the home node (net_op 2).
- R9: An exclusive eviction (req_op 3) writes the data into memory as exclusive with the inclusion bit clear, if the block is present or a free slot exists. Otherwise it sends the data to the home node (net_op 3).
- R10: A write miss (req_op 4) that finds the block exclusive is served locally. The block stays exclusive with the inclusion bit set, and the cache receives a fill (cc_op 2) carrying the stored data. Otherwise the miss goes to the home node (net_op 4).
- R11: While a cache acknowledgement is outstanding, `req_ready` is 0 and incoming requests are neither accepted nor acted on. An acknowledgement that arrives while nothing is outstanding has no effect.
- R12: Every network message carries the request's block address and the node ID parameter (default 3) as source. Every accepted request of a defined type produces at least one cache, network or memory action in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Handler can accept a request |
| req_op | input | 3 | Request type (0 inv, 1 ext read, 2 shared evict, 3 excl evict, 4 write miss) |
| req_addr | input | ADDR_W | Block address |
| req_data | input | DATA_W | Eviction data |
| am_lk_addr | output | ADDR_W | Lookup address to attraction memory |
| am_hit | input | 1 | Lookup tag match |
| am_state | input | 2 | Lookup state (0 I, 1 S, 2 E, 3 M) |
| am_incl | input | 1 | Lookup inclusion bit |
| am_data | input | DATA_W | Lookup stored data |
| am_slot_free | input | 1 | A slot can take the block |
| am_wr_en | output | 1 | Memory write strobe |
| am_wr_addr | output | ADDR_W | Write address |
| am_wr_state | output | 2 | New state |
| am_wr_incl | output | 1 | New inclusion bit |
| am_wr_data_en | output | 1 | Data field is written too |
| am_wr_data | output | DATA_W | Data to write |
| cc_valid | output | 1 | Cache command strobe |
| cc_op | output | 2 | Cache command (0 inv, 1 fetch, 2 fill, 3 inv with direct ack) |
| cc_addr | output | ADDR_W | Cache command address |
| cc_data | output | DATA_W | Fill data |
| cc_ack_valid | input | 1 | Cache acknowledgement |
| cc_ack_data | input | DATA_W | Data returned by cache |
| net_valid | output | 1 | Network message strobe |
| net_op | output | 3 | Message type (0 inv ack, 1 read reply, 2 replace home, 3 writeback home, 4 write miss home) |
| net_addr | output | ADDR_W | Block address |
| net_src | output | NODE_W | Source node ID |
| net_data | output | DATA_W | Message data |

## Verification
Each result that needs no cache help appears one cycle after the edge that accepts the request. A cache command appears one cycle after acceptance. The final memory write and network message of a waiting case appear one cycle after the edge that takes the cache acknowledgement. Every scenario task drives inputs on a falling edge, lets one rising edge pass, and samples at the next falling edge, where those registered pulses are stable. The hold-off case offers a competing request inside the waiting window and checks that nothing leaves the block before the acknowledgement.

// File: rtl/incl_coh_pkg.sv
package incl_coh_pkg;

    typedef enum logic [2:0] {
        RQ_INV = 3'd0, RQ_XRD = 3'd1, RQ_EVS = 3'd2, RQ_EVX = 3'd3, RQ_WMS = 3'd4
    } req_op_e;

    typedef enum logic [1:0] {
        AM_I = 2'd0, AM_S = 2'd1, AM_E = 2'd2, AM_M = 2'd3
    } am_st_e;

    typedef enum logic [1:0] {
        CC_INV = 2'd0, CC_FETCH = 2'd1, CC_FILL = 2'd2, CC_INV_FWD = 2'd3
    } cc_op_e;

    typedef enum logic [2:0] {
        NT_INV_ACK = 3'd0, NT_RD_REPLY = 3'd1, NT_REPL_HOME = 3'd2,
        NT_WB_HOME = 3'd3, NT_WMISS_HOME = 3'd4
    } net_op_e;

    typedef enum logic [1:0] {
        DS_NONE = 2'd0, DS_REQ = 2'd1, DS_AM = 2'd2, DS_ACK = 2'd3
    } dsel_e;

    typedef struct packed {
        logic    cc_go;
        cc_op_e  cc_op;
        dsel_e   cc_dsel;
        logic    wait_ack;
        logic    am_go;
        am_st_e  am_st;
        logic    am_incl;
        logic    am_dat_go;
        dsel_e   am_dsel;
        logic    net_go;
        net_op_e net_op;
        dsel_e   net_dsel;
    } act_t;

    // Action for a request at the moment it is accepted.
    function automatic act_t plan_accept(logic [2:0] op, logic present,
                                         am_st_e st, logic incl, logic slot_free);
        act_t a;
        a = '0;
        case (op)
            RQ_INV: begin
                if (present && incl) begin
                    a.cc_go = 1'b1; a.cc_op = CC_INV; a.wait_ack = 1'b1;
                end else if (present) begin
                    a.am_go = 1'b1; a.am_st = AM_I; a.am_incl = 1'b0;
                    a.net_go = 1'b1; a.net_op = NT_INV_ACK;
                end else begin
                    a.cc_go = 1'b1; a.cc_op = CC_INV_FWD;
                end
            end
            RQ_XRD: begin
                if (!present || (st == AM_E && incl)) begin
                    a.cc_go = 1'b1; a.cc_op = CC_FETCH; a.wait_ack = 1'b1;
                end else begin
                    a.net_go = 1'b1; a.net_op = NT_RD_REPLY; a.net_dsel = DS_AM;
                    if (st == AM_E) begin
                        a.am_go = 1'b1; a.am_st = AM_S; a.am_incl = incl;
                    end
                end
            end
            RQ_EVS: begin
                if (present) begin
                    a.am_go = 1'b1; a.am_st = st; a.am_incl = 1'b0;
                end else begin
                    a.net_go = 1'b1; a.net_op = NT_REPL_HOME;
                end
            end
            RQ_EVX: begin
                if (present || slot_free) begin
                    a.am_go = 1'b1; a.am_st = AM_E; a.am_incl = 1'b0;
                    a.am_dat_go = 1'b1; a.am_dsel = DS_REQ;
                end else begin
                    a.net_go = 1'b1; a.net_op = NT_WB_HOME; a.net_dsel = DS_REQ;
                end
            end
            RQ_WMS: begin
                if (present && st == AM_E) begin
                    a.am_go = 1'b1; a.am_st = AM_E; a.am_incl = 1'b1;
                    a.cc_go = 1'b1; a.cc_op = CC_FILL; a.cc_dsel = DS_AM;
                end else begin
                    a.net_go = 1'b1; a.net_op = NT_WMISS_HOME;
                end
            end
            default: a = '0;
        endcase
        return a;
    endfunction

    // Action once the cache has acknowledged a waiting request.
    function automatic act_t plan_finish(logic [2:0] op, logic present);
        act_t a;
        a = '0;
        if (op == RQ_INV) begin
            a.am_go = 1'b1; a.am_st = AM_I; a.am_incl = 1'b0;
            a.net_go = 1'b1; a.net_op = NT_INV_ACK;
        end else begin
            a.net_go = 1'b1; a.net_op = NT_RD_REPLY; a.net_dsel = DS_ACK;
            if (present) begin
                a.am_go = 1'b1; a.am_st = AM_S; a.am_incl = 1'b1;
                a.am_dat_go = 1'b1; a.am_dsel = DS_ACK;
            end
        end
        return a;
    endfunction

endpackage

// File: rtl/incl_coh_decide.sv
module incl_coh_decide
    import incl_coh_pkg::*;
(
    input  logic [2:0] req_op,
    input  logic       am_hit,
    input  logic [1:0] am_state,
    input  logic       am_incl,
    input  logic       am_slot_free,
    input  logic [2:0] p_op,
    input  logic       p_present,
    output logic       present,
    output act_t       acc,
    output act_t       fin
);
    am_st_e st;

    always_comb begin
        st      = am_st_e'(am_state);
        present = am_hit && (st != AM_I);
        acc     = plan_accept(req_op, present, st, am_incl, am_slot_free);
        fin     = plan_finish(p_op, p_present);
    end
endmodule

// File: rtl/incl_coh_seq.sv
module incl_coh_seq
    import incl_coh_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 64,
    parameter int NODE_W  = 4,
    parameter int NODE_ID = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic [DATA_W-1:0] am_data,
    input  logic              present,
    input  act_t              acc,
    input  act_t              fin,
    output logic [2:0]        p_op,
    output logic              p_present,
    output logic              am_wr_en,
    output logic [ADDR_W-1:0] am_wr_addr,
    output logic [1:0]        am_wr_state,
    output logic              am_wr_incl,
    output logic              am_wr_data_en,
    output logic [DATA_W-1:0] am_wr_data,
    output logic              cc_valid,
    output logic [1:0]        cc_op,
    output logic [ADDR_W-1:0] cc_addr,
    output logic [DATA_W-1:0] cc_data,
    input  logic              cc_ack_valid,
    input  logic [DATA_W-1:0] cc_ack_data,
    output logic              net_valid,
    output logic [2:0]        net_op,
    output logic [ADDR_W-1:0] net_addr,
    output logic [NODE_W-1:0] net_src,
    output logic [DATA_W-1:0] net_data
);
    localparam logic [NODE_W-1:0] SRC_ID = NODE_W'(NODE_ID);

    logic              busy;
    logic [ADDR_W-1:0] p_addr;
    logic              take_req;
    logic              take_ack;
    act_t              act;
    logic [ADDR_W-1:0] act_addr;

    function automatic logic [DATA_W-1:0] pick(dsel_e s, logic [DATA_W-1:0] rd,
                                               logic [DATA_W-1:0] ad,
                                               logic [DATA_W-1:0] kd);
        case (s)
            DS_REQ:  return rd;
            DS_AM:   return ad;
            DS_ACK:  return kd;
            default: return '0;
        endcase
    endfunction

    assign req_ready = !busy;
    assign take_req  = req_valid && !busy;
    assign take_ack  = cc_ack_valid && busy;

    always_comb begin
        act      = take_req ? acc : fin;
        act_addr = take_req ? req_addr : p_addr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy          <= 1'b0;
            p_op          <= '0;
            p_present     <= 1'b0;
            p_addr        <= '0;
            am_wr_en      <= 1'b0;
            am_wr_addr    <= '0;
            am_wr_state   <= '0;
            am_wr_incl    <= 1'b0;
            am_wr_data_en <= 1'b0;
            am_wr_data    <= '0;
            cc_valid      <= 1'b0;
            cc_op         <= '0;
            cc_addr       <= '0;
            cc_data       <= '0;
            net_valid     <= 1'b0;
            net_op        <= '0;
            net_addr      <= '0;
            net_src       <= '0;
            net_data      <= '0;
        end else begin
            am_wr_en  <= 1'b0;
            cc_valid  <= 1'b0;
            net_valid <= 1'b0;
            if (take_req || take_ack) begin
                if (take_req) begin
                    busy      <= acc.wait_ack;
                    p_op      <= req_op;
                    p_present <= present;
                    p_addr    <= req_addr;
                end else begin
                    busy <= 1'b0;
                end
                if (act.am_go) begin
                    am_wr_en      <= 1'b1;
                    am_wr_addr    <= act_addr;
                    am_wr_state   <= act.am_st;
                    am_wr_incl    <= act.am_incl;
                    am_wr_data_en <= act.am_dat_go;
                    am_wr_data    <= pick(act.am_dsel, req_data, am_data, cc_ack_data);
                end
                if (act.cc_go) begin
                    cc_valid <= 1'b1;
                    cc_op    <= act.cc_op;
                    cc_addr  <= act_addr;
                    cc_data  <= pick(act.cc_dsel, req_data, am_data, cc_ack_data);
                end
                if (act.net_go) begin
                    net_valid <= 1'b1;
                    net_op    <= act.net_op;
                    net_addr  <= act_addr;
                    net_src   <= SRC_ID;
                    net_data  <= pick(act.net_dsel, req_data, am_data, cc_ack_data);
                end
            end
        end
    end

    AST_CMD_HOLDS_READY: assert property (@(posedge clk) disable iff (rst)
        (cc_valid && (cc_op == CC_INV || cc_op == CC_FETCH)) |-> !req_ready); // R11
    AST_ACCEPT_ACTS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_op <= 3'd4) |=> (cc_valid || net_valid || am_wr_en)); // R12
    AST_INVAL_ACKS: assert property (@(posedge clk) disable iff (rst)
        (am_wr_en && am_wr_state == AM_I) |-> (net_valid && net_op == NT_INV_ACK)); // R2
    AST_FILL_INCL: assert property (@(posedge clk) disable iff (rst)
        (cc_valid && cc_op == CC_FILL) |-> (am_wr_en && am_wr_incl)); // R10
    AST_FETCH_QUIET: assert property (@(posedge clk) disable iff (rst)
        (cc_valid && cc_op == CC_FETCH) |-> (!net_valid && !am_wr_en)); // R5
    AST_SRC_FIXED: assert property (@(posedge clk) disable iff (rst)
        net_valid |-> (net_src == SRC_ID)); // R12
endmodule

// File: rtl/incl_coh_ctrl.sv
module incl_coh_ctrl
    import incl_coh_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 64,
    parameter int NODE_W  = 4,
    parameter int NODE_ID = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic [ADDR_W-1:0] am_lk_addr,
    input  logic              am_hit,
    input  logic [1:0]        am_state,
    input  logic              am_incl,
    input  logic [DATA_W-1:0] am_data,
    input  logic              am_slot_free,
    output logic              am_wr_en,
    output logic [ADDR_W-1:0] am_wr_addr,
    output logic [1:0]        am_wr_state,
    output logic              am_wr_incl,
    output logic              am_wr_data_en,
    output logic [DATA_W-1:0] am_wr_data,
    output logic              cc_valid,
    output logic [1:0]        cc_op,
    output logic [ADDR_W-1:0] cc_addr,
    output logic [DATA_W-1:0] cc_data,
    input  logic              cc_ack_valid,
    input  logic [DATA_W-1:0] cc_ack_data,
    output logic              net_valid,
    output logic [2:0]        net_op,
    output logic [ADDR_W-1:0] net_addr,
    output logic [NODE_W-1:0] net_src,
    output logic [DATA_W-1:0] net_data
);
    logic       present;
    act_t       acc;
    act_t       fin;
    logic [2:0] p_op;
    logic       p_present;

    assign am_lk_addr = req_addr;

    incl_coh_decide u_decide (
        .req_op       (req_op),
        .am_hit       (am_hit),
        .am_state     (am_state),
        .am_incl      (am_incl),
        .am_slot_free (am_slot_free),
        .p_op         (p_op),
        .p_present    (p_present),
        .present      (present),
        .acc          (acc),
        .fin          (fin)
    );

    incl_coh_seq #(
        .ADDR_W (ADDR_W), .DATA_W (DATA_W), .NODE_W (NODE_W), .NODE_ID (NODE_ID)
    ) u_seq (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_op        (req_op),
        .req_addr      (req_addr),
        .req_data      (req_data),
        .am_data       (am_data),
        .present       (present),
        .acc           (acc),
        .fin           (fin),
        .p_op          (p_op),
        .p_present     (p_present),
        .am_wr_en      (am_wr_en),
        .am_wr_addr    (am_wr_addr),
        .am_wr_state   (am_wr_state),
        .am_wr_incl    (am_wr_incl),
        .am_wr_data_en (am_wr_data_en),
        .am_wr_data    (am_wr_data),
        .cc_valid      (cc_valid),
        .cc_op         (cc_op),
        .cc_addr       (cc_addr),
        .cc_data       (cc_data),
        .cc_ack_valid  (cc_ack_valid),
        .cc_ack_data   (cc_ack_data),
        .net_valid     (net_valid),
        .net_op        (net_op),
        .net_addr      (net_addr),
        .net_src       (net_src),
        .net_data      (net_data)
    );
endmodule

// File: tb/incl_coh_ctrl_test.sv
module incl_coh_ctrl_test;
    localparam int AW = 32;
    localparam int DW = 64;
    localparam int NW = 4;
    localparam logic [NW-1:0] ME = 4'd3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [2:0]    req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic [AW-1:0] am_lk_addr;
    logic          am_hit = 1'b0;
    logic [1:0]    am_state = '0;
    logic          am_incl = 1'b0;
    logic [DW-1:0] am_data = '0;
    logic          am_slot_free = 1'b0;
    logic          am_wr_en;
    logic [AW-1:0] am_wr_addr;
    logic [1:0]    am_wr_state;
    logic          am_wr_incl;
    logic          am_wr_data_en;
    logic [DW-1:0] am_wr_data;
    logic          cc_valid;
    logic [1:0]    cc_op;
    logic [AW-1:0] cc_addr;
    logic [DW-1:0] cc_data;
    logic          cc_ack_valid = 1'b0;
    logic [DW-1:0] cc_ack_data = '0;
    logic          net_valid;
    logic [2:0]    net_op;
    logic [AW-1:0] net_addr;
    logic [NW-1:0] net_src;
    logic [DW-1:0] net_data;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    incl_coh_ctrl uut (.*);

    task automatic chk(input string rq, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic logic [127:0] netv();
        return {net_valid, net_op, net_addr, net_src, net_data};
    endfunction
    function automatic logic [127:0] amv();
        return {am_wr_en, am_wr_addr, am_wr_state, am_wr_incl, am_wr_data_en};
    endfunction
    function automatic logic [127:0] ccv();
        return {cc_valid, cc_op, cc_addr};
    endfunction

    task automatic go(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic hit, input logic [1:0] st, input logic incl,
                      input logic freeslot, input logic [DW-1:0] amd);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
        am_hit = hit; am_state = st; am_incl = incl; am_slot_free = freeslot; am_data = amd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic ack(input logic [DW-1:0] d);
        cc_ack_valid = 1'b1; cc_ack_data = d;
        @(posedge clk);
        @(negedge clk);
        cc_ack_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 ready", 128'(req_ready), 128'(1));
        chk("R1 idle", 128'({cc_valid, net_valid, am_wr_en}), 128'(0));
    endtask

    task automatic t_inv_incl;
        logic [AW-1:0] a = 32'h0000_1040;
        go(3'd0, a, '0, 1'b1, 2'd1, 1'b1, 1'b0, 64'h11);
        chk("R2 cache inv", ccv(), {1'b1, 2'd0, a});
        chk("R2 no net yet", 128'({net_valid, am_wr_en}), 128'(0));
        chk("R11 busy", 128'(req_ready), 128'(0));
        go(3'd1, 32'h0000_2000, '0, 1'b1, 2'd1, 1'b0, 1'b0, 64'h22);
        chk("R11 held request", 128'({net_valid, cc_valid, am_wr_en, req_ready}), 128'(0));
        ack(64'h0);
        chk("R2 am invalid", amv(), {1'b1, a, 2'd0, 1'b0, 1'b0});
        chk("R2 inv ack", netv(), {1'b1, 3'd0, a, ME, 64'h0});
        chk("R11 ready again", 128'(req_ready), 128'(1));
    endtask

    task automatic t_inv_plain;
        logic [AW-1:0] a = 32'h0000_3300;
        go(3'd0, a, '0, 1'b1, 2'd3, 1'b0, 1'b0, 64'h33);
        chk("R3 am invalid", amv(), {1'b1, a, 2'd0, 1'b0, 1'b0});
        chk("R3 inv ack", netv(), {1'b1, 3'd0, a, ME, 64'h0});
        chk("R3 no cache", 128'(cc_valid), 128'(0));
        a = 32'h0000_3340;
        go(3'd0, a, '0, 1'b0, 2'd0, 1'b0, 1'b0, 64'h0);
        chk("R4 direct inv", ccv(), {1'b1, 2'd3, a});
        chk("R4 nothing else", 128'({net_valid, am_wr_en}), 128'(0));
        chk("R4 not waiting", 128'(req_ready), 128'(1));
    endtask

    task automatic t_xrd;
        logic [AW-1:0] a = 32'h0000_4400;
        go(3'd1, a, '0, 1'b1, 2'd2, 1'b1, 1'b0, 64'hDEAD);
        chk("R5 fetch", ccv(), {1'b1, 2'd1, a});
        ack(64'hCAFE_F00D);
        chk("R5 am shared", amv(), {1'b1, a, 2'd1, 1'b1, 1'b1});
        chk("R5 am data", 128'(am_wr_data), 128'(64'hCAFE_F00D));
        chk("R5 reply", netv(), {1'b1, 3'd1, a, ME, 64'hCAFE_F00D});
        a = 32'h0000_4480;
        go(3'd1, a, '0, 1'b1, 2'd2, 1'b0, 1'b0, 64'h5555);
        chk("R6 reply am data", netv(), {1'b1, 3'd1, a, ME, 64'h5555});
        chk("R6 downgrade", amv(), {1'b1, a, 2'd1, 1'b0, 1'b0});
        go(3'd1, a, '0, 1'b1, 2'd3, 1'b1, 1'b0, 64'h6666);
        chk("R6 master reply", netv(), {1'b1, 3'd1, a, ME, 64'h6666});
        chk("R6 no write", 128'({am_wr_en, cc_valid}), 128'(0));
        a = 32'h0000_44C0;
        go(3'd1, a, '0, 1'b0, 2'd0, 1'b0, 1'b1, 64'h0);
        chk("R7 fetch", ccv(), {1'b1, 2'd1, a});
        ack(64'h7777);
        chk("R7 reply", netv(), {1'b1, 3'd1, a, ME, 64'h7777});
        chk("R7 no write", 128'(am_wr_en), 128'(0));
    endtask

    task automatic t_evict;
        logic [AW-1:0] a = 32'h0000_5500;
        go(3'd2, a, '0, 1'b1, 2'd3, 1'b1, 1'b0, 64'h0);
        chk("R8 clear incl", amv(), {1'b1, a, 2'd3, 1'b0, 1'b0});
        chk("R8 no net", 128'(net_valid), 128'(0));
        go(3'd2, a, '0, 1'b0, 2'd0, 1'b0, 1'b1, 64'h0);
        chk("R8 repl home", netv(), {1'b1, 3'd2, a, ME, 64'h0});
        chk("R8 no write", 128'(am_wr_en), 128'(0));
        go(3'd3, a, 64'hAAAA, 1'b1, 2'd2, 1'b1, 1'b0, 64'h0);
        chk("R9 wb hit", amv(), {1'b1, a, 2'd2, 1'b0, 1'b1});
        chk("R9 wb data", 128'(am_wr_data), 128'(64'hAAAA));
        go(3'd3, a, 64'hBBBB, 1'b0, 2'd0, 1'b0, 1'b1, 64'h0);
        chk("R9 wb free slot", amv(), {1'b1, a, 2'd2, 1'b0, 1'b1});
        go(3'd3, a, 64'hCCCC, 1'b0, 2'd0, 1'b0, 1'b0, 64'h0);
        chk("R9 wb home", netv(), {1'b1, 3'd3, a, ME, 64'hCCCC});
        chk("R9 no write", 128'(am_wr_en), 128'(0));
    endtask

    task automatic t_wmiss;
        logic [AW-1:0] a = 32'h0000_6600;
        go(3'd4, a, '0, 1'b1, 2'd2, 1'b0, 1'b0, 64'h1234);
        chk("R10 set incl", amv(), {1'b1, a, 2'd2, 1'b1, 1'b0});
        chk("R10 fill", ccv(), {1'b1, 2'd2, a});
        chk("R10 fill data", 128'(cc_data), 128'(64'h1234));
        go(3'd4, a, '0, 1'b1, 2'd1, 1'b0, 1'b0, 64'h1234);
        chk("R10 miss home", netv(), {1'b1, 3'd4, a, ME, 64'h0});
        chk("R12 src id", 128'(net_src), 128'(ME));
    endtask

    task automatic t_stray_ack;
        @(negedge clk);
        ack(64'h9999);
        chk("R11 stray ack", 128'({net_valid, cc_valid, am_wr_en, req_ready}), 128'(1));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_inv_incl();
        t_inv_plain();
        t_xrd();
        t_evict();
        t_wmiss();
        t_stray_ack();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule